// File: doc/BRIEF.md
# Send-DMA Engine Control Sequencer

This block sequences a send-DMA engine through bring-up, normal operation, orderly stopping, error recovery and shutdown. The surrounding logic reports what happens as single-cycle event pulses: requests from the control path, completions from the engine, and two different kinds of error halt. From these the sequencer picks one of seven states. Each state drives a fixed set of level controls for the engine: enable, interrupt enable, halt and drain.

Work the sequencer cannot do itself is handed out as one-cycle request pulses. These cover disarming the send buffers and restarting the hardware, cleaning the hardware side, and cleaning the software side. Completion comes back later as another event. A sticky run-pending flag remembers a request to run that arrives while the engine is starting or recovering, so that bring-up ends in running rather than idle. The last accepted event and the state before the most recent transition are kept for debug readout.

Top module: `dma_ctl_fsm`

## Requirements
- R1: After reset the state is hardware-down (code 0), run_pending is 0, halt is 1, enable, interrupt enable and drain are 0, no request or stopped pulse is high, last_evt is 15 and prev_state is 0.
- R2: Event bits of evt are: 0 go-down, 1 go-start, 2 hw-started, 3 go-run, 4 sw-cleaned, 5 hw-cleaned, 6 hw-halted, 7 go-idle, 8 error-halt A, 9 error-halt B, 10 timer tick. In hardware-down, go-start moves to start-up wait (code 1); go-run does the same and also sets run_pending.
- R3: In start-up wait, hw-started moves to running (code 6) if run_pending is 1 and to idle (code 2) otherwise. In idle, go-run moves to running and sets run_pending.
- R4: Enable and interrupt enable are 1 only in running. Halt is 1 in every other state. Drain is 1 only in halt wait (code 5) and hardware-cleanup wait (code 4).
- R5: In running, go-idle moves to halt wait and clears run_pending. In halt wait, hw-halted moves to hardware-cleanup wait and pulses req_hw_clean. In hardware-cleanup wait, hw-cleaned moves to software-cleanup wait (code 3) and pulses req_sw_clean. In software-cleanup wait, sw-cleaned moves to start-up wait and pulses req_hw_start. Every request is high for exactly the one cycle after the event edge, alongside the new state.
- R6: In running, hw-halted or error-halt A moves to software-cleanup wait and pulses req_sw_clean. Error-halt B moves to halt wait with no request and leaves run_pending set, so the recovery ends in running.
- R7: Go-down from running, halt wait or hardware-cleanup wait moves to hardware-down and pulses req_sw_clean. From start-up wait or idle it moves to hardware-down and pulses stopped. From software-cleanup wait it moves to hardware-down with no pulse. A sw-cleaned event in hardware-down pulses stopped. Go-down leaves run_pending unchanged.
- R8: In start-up wait, halt wait, hardware-cleanup wait and software-cleanup wait, go-run sets run_pending and go-idle clears it, without changing the state.
- R9: The timer tick, and any event not listed for the current state, changes neither the state nor run_pending and raises no pulse.
- R10: An evt word with more than one bit set is ignored entirely, including by last_evt.
- R11: last_evt holds the bit index of the last single-bit event received, whether or not it acted. prev_state holds the state left by the most recent state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | 11 | One-hot event pulses |
| state | output | 3 | Current state code |
| run_pending | output | 1 | Sticky go-running flag |
| ctl_enable | output | 1 | Engine enable |
| ctl_int_en | output | 1 | Engine interrupt enable |
| ctl_halt | output | 1 | Engine halt |
| ctl_drain | output | 1 | Engine drain |
| req_hw_start | output | 1 | Pulse: disarm buffers and start hardware |
| req_hw_clean | output | 1 | Pulse: start hardware cleanup |
| req_sw_clean | output | 1 | Pulse: start software cleanup |
| stopped | output | 1 | Pulse: engine has fully stopped |
| last_evt | output | 4 | Index of last accepted event |
| prev_state | output | 3 | State before the latest transition |

## Verification
Directed event sequences drive the machine down each path: plain bring-up to idle and then running, the orderly go-idle path through both cleanups, and the two error halts. Comparing those paths shows whether error-halt A and error-halt B are routed to their separate recoveries. Run and idle requests issued in the middle of the wait states show whether the sticky flag decides where a later start-up ends. Go-down is tried from several states to separate the software-cleanup, stopped and silent outcomes. Ticks, events that do not apply to the current state, and multi-bit words are applied in running to confirm they have no effect.

// File: rtl/dma_ctl_fsm.sv
module dma_ctl_fsm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [10:0] evt,
  output logic [2:0]  state,
  output logic        run_pending,
  output logic        ctl_enable,
  output logic        ctl_int_en,
  output logic        ctl_halt,
  output logic        ctl_drain,
  output logic        req_hw_start,
  output logic        req_hw_clean,
  output logic        req_sw_clean,
  output logic        stopped,
  output logic [3:0]  last_evt,
  output logic [2:0]  prev_state
);
  localparam logic [2:0] S_DOWN = 3'd0, S_START = 3'd1, S_IDLE = 3'd2,
                         S_SWCLN = 3'd3, S_HWCLN = 3'd4, S_HALTW = 3'd5,
                         S_RUN = 3'd6;
  localparam int E_DOWN = 0, E_GOSTART = 1, E_STARTED = 2, E_GORUN = 3,
                 E_SWDONE = 4, E_HWDONE = 5, E_HALTED = 6, E_GOIDLE = 7,
                 E_ERRA = 8, E_ERRB = 9, E_TICK = 10;

  logic [2:0] st, st_n;
  logic       flag, flag_n;
  logic       r_start, r_hwc, r_swc, r_stop;
  logic       valid;
  logic [10:0] e;
  logic [3:0] idx;

  assign valid = (evt != '0) && ((evt & (evt - 11'd1)) == '0);
  assign e     = valid ? evt : '0;

  always_comb begin
    idx = '0;
    for (int i = 0; i < 11; i++)
      if (evt[i]) idx = 4'(i);
  end

  always_comb begin
    st_n = st; flag_n = flag;
    r_start = 1'b0; r_hwc = 1'b0; r_swc = 1'b0; r_stop = 1'b0;
    case (st)
      S_DOWN: begin
        if (e[E_GORUN]) begin flag_n = 1'b1; st_n = S_START; end
        else if (e[E_GOSTART]) st_n = S_START;
        else if (e[E_SWDONE]) r_stop = 1'b1;
      end
      S_START: begin
        if (e[E_DOWN]) begin st_n = S_DOWN; r_stop = 1'b1; end
        else if (e[E_STARTED]) st_n = flag ? S_RUN : S_IDLE;
      end
      S_IDLE: begin
        if (e[E_DOWN]) begin st_n = S_DOWN; r_stop = 1'b1; end
        else if (e[E_GORUN]) begin st_n = S_RUN; flag_n = 1'b1; end
      end
      S_SWCLN: begin
        if (e[E_DOWN]) st_n = S_DOWN;
        else if (e[E_SWDONE]) begin st_n = S_START; r_start = 1'b1; end
      end
      S_HWCLN: begin
        if (e[E_DOWN]) begin st_n = S_DOWN; r_swc = 1'b1; end
        else if (e[E_HWDONE]) begin st_n = S_SWCLN; r_swc = 1'b1; end
      end
      S_HALTW: begin
        if (e[E_DOWN]) begin st_n = S_DOWN; r_swc = 1'b1; end
        else if (e[E_HALTED]) begin st_n = S_HWCLN; r_hwc = 1'b1; end
      end
      S_RUN: begin
        if (e[E_DOWN]) begin st_n = S_DOWN; r_swc = 1'b1; end
        else if (e[E_HALTED] || e[E_ERRA]) begin st_n = S_SWCLN; r_swc = 1'b1; end
        else if (e[E_GOIDLE]) begin st_n = S_HALTW; flag_n = 1'b0; end
        else if (e[E_ERRB]) st_n = S_HALTW;
      end
      default: st_n = S_DOWN;
    endcase
    if (st == S_START || st == S_SWCLN || st == S_HWCLN || st == S_HALTW) begin
      if (e[E_GORUN]) flag_n = 1'b1;
      if (e[E_GOIDLE]) flag_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_DOWN; flag <= 1'b0;
      req_hw_start <= 1'b0; req_hw_clean <= 1'b0;
      req_sw_clean <= 1'b0; stopped <= 1'b0;
      last_evt <= 4'hF; prev_state <= S_DOWN;
    end else begin
      st <= st_n; flag <= flag_n;
      req_hw_start <= r_start; req_hw_clean <= r_hwc;
      req_sw_clean <= r_swc; stopped <= r_stop;
      if (valid) last_evt <= idx;
      if (st_n != st) prev_state <= st;
    end
  end

  assign state       = st;
  assign run_pending = flag;
  assign ctl_enable  = (st == S_RUN);
  assign ctl_int_en  = ctl_enable;
  assign ctl_halt    = !ctl_enable;
  assign ctl_drain   = (st == S_HALTW) || (st == S_HWCLN);

  p_start_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && evt == 11'h004) |=> (state == ($past(flag) ? S_RUN : S_IDLE)));
  p_go_idle_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && evt == 11'h080) |=> (state == S_HALTW && !run_pending && ctl_drain));
  p_req_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_hw_start, req_hw_clean, req_sw_clean, stopped}));
  p_stop_in_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> state == S_DOWN);
  p_errb_keeps_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && evt == 11'h200) |=> (state == S_HALTW && $stable(run_pending) && !req_sw_clean));
  p_tick_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == 11'h400) |=> ($stable(state) && $stable(run_pending)));
  p_multi_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(evt) > 1) |=> ($stable(state) && $stable(last_evt) && $stable(run_pending)));
endmodule

// File: tb/tb_dma_ctl_fsm.sv
module tb_dma_ctl_fsm;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [10:0] evt = '0;
  logic [2:0] state, prev_state;
  logic run_pending, ctl_enable, ctl_int_en, ctl_halt, ctl_drain;
  logic req_hw_start, req_hw_clean, req_sw_clean, stopped;
  logic [3:0] last_evt;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dma_ctl_fsm dut (.clk(clk), .rst_n(rst_n), .evt(evt), .state(state),
    .run_pending(run_pending), .ctl_enable(ctl_enable), .ctl_int_en(ctl_int_en),
    .ctl_halt(ctl_halt), .ctl_drain(ctl_drain), .req_hw_start(req_hw_start),
    .req_hw_clean(req_hw_clean), .req_sw_clean(req_sw_clean), .stopped(stopped),
    .last_evt(last_evt), .prev_state(prev_state));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fire_word(input logic [10:0] w);
    @(negedge clk) evt = w;
    @(negedge clk) evt = '0;
  endtask

  task automatic fire(input int i);
    fire_word(11'(1) << i);
  endtask

  task automatic pulses(input string req, input int s, input int h, input int c, input int p);
    chk(req, "req_hw_start", int'(req_hw_start), s);
    chk(req, "req_hw_clean", int'(req_hw_clean), h);
    chk(req, "req_sw_clean", int'(req_sw_clean), c);
    chk(req, "stopped", int'(stopped), p);
  endtask

  task automatic t_reset;
    chk("R1", "state", int'(state), 0);
    chk("R1", "run_pending", int'(run_pending), 0);
    chk("R1", "halt", int'(ctl_halt), 1);
    chk("R1", "enable", int'(ctl_enable), 0);
    chk("R1", "drain", int'(ctl_drain), 0);
    chk("R1", "last_evt", int'(last_evt), 15);
    chk("R1", "prev_state", int'(prev_state), 0);
    pulses("R1", 0, 0, 0, 0);
  endtask

  task automatic t_bringup_idle;
    fire(1);
    chk("R2", "state after go-start", int'(state), 1);
    chk("R2", "flag after go-start", int'(run_pending), 0);
    fire(2);
    chk("R3", "state to idle", int'(state), 2);
    chk("R4", "halt in idle", int'(ctl_halt), 1);
    chk("R4", "enable in idle", int'(ctl_enable), 0);
    chk("R11", "prev_state", int'(prev_state), 1);
    chk("R11", "last_evt", int'(last_evt), 2);
    fire(3);
    chk("R3", "idle go-run state", int'(state), 6);
    chk("R3", "idle go-run flag", int'(run_pending), 1);
    chk("R4", "enable in run", int'(ctl_enable), 1);
    chk("R4", "int_en in run", int'(ctl_int_en), 1);
    chk("R4", "halt in run", int'(ctl_halt), 0);
  endtask

  task automatic t_ignored;
    fire(10);
    chk("R9", "tick state", int'(state), 6);
    chk("R9", "tick flag", int'(run_pending), 1);
    chk("R11", "last_evt tick", int'(last_evt), 10);
    fire(1);
    chk("R9", "go-start in run", int'(state), 6);
    pulses("R9", 0, 0, 0, 0);
    fire_word(11'h0C0);
    chk("R10", "multi-bit state", int'(state), 6);
    chk("R10", "multi-bit last_evt", int'(last_evt), 1);
    pulses("R10", 0, 0, 0, 0);
  endtask

  task automatic t_orderly;
    fire(7);
    chk("R5", "go-idle state", int'(state), 5);
    chk("R5", "go-idle flag", int'(run_pending), 0);
    chk("R4", "drain halt-wait", int'(ctl_drain), 1);
    fire(3);
    chk("R8", "go-run in halt-wait state", int'(state), 5);
    chk("R8", "go-run in halt-wait flag", int'(run_pending), 1);
    fire(6);
    chk("R5", "hw-halted state", int'(state), 4);
    pulses("R5", 0, 1, 0, 0);
    @(negedge clk);
    chk("R5", "hw_clean pulse width", int'(req_hw_clean), 0);
    chk("R4", "drain hw-clean", int'(ctl_drain), 1);
    fire(5);
    chk("R5", "hw-cleaned state", int'(state), 3);
    pulses("R5", 0, 0, 1, 0);
    chk("R4", "drain sw-clean", int'(ctl_drain), 0);
    fire(7);
    chk("R8", "go-idle in sw-clean flag", int'(run_pending), 0);
    chk("R8", "go-idle in sw-clean state", int'(state), 3);
    fire(3);
    chk("R8", "go-run in sw-clean flag", int'(run_pending), 1);
    fire(4);
    chk("R5", "sw-cleaned state", int'(state), 1);
    pulses("R5", 1, 0, 0, 0);
    fire(2);
    chk("R3", "restart to run", int'(state), 6);
  endtask

  task automatic t_err_a;
    fire(8);
    chk("R6", "err A state", int'(state), 3);
    pulses("R6", 0, 0, 1, 0);
    fire(4); fire(2);
    chk("R6", "err A recovery", int'(state), 6);
  endtask

  task automatic t_err_b;
    fire(9);
    chk("R6", "err B state", int'(state), 5);
    chk("R6", "err B flag", int'(run_pending), 1);
    pulses("R6", 0, 0, 0, 0);
    fire(6); fire(5); fire(4); fire(2);
    chk("R6", "err B recovery", int'(state), 6);
  endtask

  task automatic t_down;
    fire(0);
    chk("R7", "down from run", int'(state), 0);
    pulses("R7", 0, 0, 1, 0);
    chk("R7", "flag kept", int'(run_pending), 1);
    fire(4);
    chk("R7", "sw-cleaned in down state", int'(state), 0);
    pulses("R7", 0, 0, 0, 1);
    fire(1); fire(7);
    chk("R8", "go-idle in start-up", int'(run_pending), 0);
    fire(0);
    chk("R7", "down from start-up", int'(state), 0);
    pulses("R7", 0, 0, 0, 1);
    fire(3);
    chk("R2", "go-run from down state", int'(state), 1);
    chk("R2", "go-run from down flag", int'(run_pending), 1);
    fire(2); fire(6);
    chk("R6", "hw-halted in run", int'(state), 3);
    fire(0);
    chk("R7", "down from sw-clean", int'(state), 0);
    pulses("R7", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bringup_idle();
    t_ignored();
    t_orderly();
    t_err_a();
    t_err_b();
    t_down();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule